// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Sequencer

This block is the device-side controller for a synchronous DRAM's mode settings and column bursts. Each clock it takes one registered command: idle, mode load, read or write. On a mode load the address bus carries the mode word. The block checks the word and, if it is legal, stores five settings: burst length, burst ordering, read latency, operating mode and write-burst policy.

For every read or write, the block produces the column address of each beat, one per clock. The order of the beats comes from the stored length, the ordering and the starting column. For reads it also drives a data-bus output-enable strobe and a data-valid strobe, which follow the programmed latency. A read or write that arrives while a burst is running cuts that burst short. The memory array, refresh, row activation and pad timing sit outside this block.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset the stored mode is burst length 1 (`cfg_blen_o`=0), sequential ordering, latency 3, write bursts enabled (`cfg_wsingle_o`=0), and `mode_err_o`=0. While no read is in flight, `rd_oe_o` and `rd_vld_o` are 0.
- R2: A mode load (`cmd_i`=1) is accepted if it passes three tests. Word bits [2:0] are 000/001/010/011, which select 1/2/4/8 beats. Bits [6:4] are 010 or 011, which select latency 2 or 3. Bits [8:7] are 00. An accepted word takes effect from the next cycle: `cfg_blen_o`=bits[1:0], `cfg_ilv_o`=bit 3, `cfg_cl_o`=bits[5:4] and `cfg_wsingle_o`=bit 9. `mode_err_o` then reads 0.
- R3: A mode word that fails any test of R2 leaves all `cfg_*` outputs unchanged and sets `mode_err_o`. The flag holds until the next mode load.
- R4: A read (`cmd_i`=2) or write (`cmd_i`=3) sampled at edge n holds `beat_o` high for L cycles starting at edge n, where L is the burst length. `beat_wr_o` marks the write beats.
- R5: With sequential ordering, beat i carries the column base + ((start mod L)+i) mod L. Here base is the start column rounded down to a multiple of L.
- R6: With interleaved ordering, beat i carries the column base + ((start mod L) XOR i).
- R7: For a read sampled at edge n with latency m, `rd_vld_o` is high for the L cycles starting at edge n+m.
- R8: For the same read, `rd_oe_o` rises at edge n+m−1, one cycle before `rd_vld_o`. It stays high until `rd_vld_o` falls.
- R9: When `cfg_wsingle_o`=1, every write has exactly one beat at the start column. Reads still use the programmed length.
- R10: A read or write sampled while a burst is running ends that burst. Its own beat 0 appears in the next cycle. A mode load does not end a running burst.
- R11: Write beats never raise `rd_oe_o` or `rd_vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Command: 0 idle, 1 mode load, 2 read, 3 write |
| addr_i | input | ADDR_W (12) | Mode word on mode load; start column on read/write |
| beat_o | output | 1 | A burst beat is active this cycle |
| beat_wr_o | output | 1 | The active beat belongs to a write |
| col_o | output | COL_W (10) | Column address of the active beat |
| rd_oe_o | output | 1 | Read data-bus output enable |
| rd_vld_o | output | 1 | Read data valid |
| mode_err_o | output | 1 | The last mode load was rejected |
| cfg_blen_o | output | 2 | Stored burst length, log2 of beats |
| cfg_ilv_o | output | 1 | Stored ordering, 1 = interleaved |
| cfg_cl_o | output | 2 | Stored read latency (2 or 3) |
| cfg_wsingle_o | output | 1 | Stored write policy, 1 = single-location writes |

## Verification
Two things can fall in the same cycle: a new command cuts a running burst short, while the read-strobe pipeline is still draining the beats of that burst. The bench provokes this by issuing a write two beats into an eight-beat read at latency 2. In the cycle where the write's beat 0 appears, the strobes for the two read beats already issued must still arrive at their own latency. Every other case is a sweep over all lengths, both orderings, both latencies, both write policies and starting columns that cover every low-bit residue. The expected column and strobe pattern for each cycle is computed arithmetically.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  localparam int BL_LOG_MAX = 3;
  localparam int BL_LOG_W   = 2;
  localparam int CNT_W      = BL_LOG_MAX;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_LMODE = 2'd1,
    CMD_READ  = 2'd2,
    CMD_WRITE = 2'd3
  } sdr_cmd_e;

  typedef struct packed {
    logic [BL_LOG_W-1:0] blen_log;
    logic                ilv;
    logic [1:0]          cl;
    logic                wsingle;
  } sdr_mode_t;
endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] word_i,
  output sdr_mode_t         mode_o,
  output logic              err_o
);
  sdr_mode_t mode_q, mode_d;
  logic      err_q, err_d;
  logic      len_ok, lat_ok, op_ok, word_ok;

  always_comb begin
    len_ok  = (word_i[2] == 1'b0);
    lat_ok  = (word_i[6:4] == 3'd2) || (word_i[6:4] == 3'd3);
    op_ok   = (word_i[8:7] == 2'd0);
    word_ok = len_ok && lat_ok && op_ok;
  end

  always_comb begin
    mode_d = mode_q;
    err_d  = err_q;
    if (ld_i) begin
      err_d = !word_ok;
      if (word_ok) begin
        mode_d.blen_log = word_i[1:0];
        mode_d.ilv      = word_i[3];
        mode_d.cl       = word_i[5:4];
        mode_d.wsingle  = word_i[9];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q.blen_log <= '0;
      mode_q.ilv      <= 1'b0;
      mode_q.cl       <= 2'd3;
      mode_q.wsingle  <= 1'b0;
      err_q           <= 1'b0;
    end else if (ld_i) begin
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;

  // R3
  bad_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && !word_ok) |=> ($stable(mode_q) && err_q));
  // R2
  good_word_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && word_ok) |=> !err_q);
  // R2
  lat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.cl == 2'd2) || (mode_q.cl == 2'd3));
endmodule

// File: rtl/sdr_beat_gen.sv
module sdr_beat_gen
  import sdr_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                wr_i,
  input  logic [COL_W-1:0]    col_i,
  input  logic [BL_LOG_W-1:0] blen_log_i,
  input  logic                ilv_i,
  input  logic                wsingle_i,
  output logic                beat_o,
  output logic                wr_o,
  output logic [COL_W-1:0]    col_o
);
  localparam int HI_W = COL_W - CNT_W;

  logic             act_q, act_d;
  logic             wr_q, wr_d;
  logic             ilv_q, ilv_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lm1_q, lm1_d;
  logic [COL_W-1:0] start_q, start_d;
  logic [CNT_W:0]   len_full;
  logic [CNT_W-1:0] low_start, seq_low, ilv_low, pick_low;

  always_comb begin
    len_full = (CNT_W+1)'(1) << blen_log_i;
    act_d    = act_q;
    wr_d     = wr_q;
    ilv_d    = ilv_q;
    cnt_d    = cnt_q;
    lm1_d    = lm1_q;
    start_d  = start_q;
    if (start_i) begin
      act_d   = 1'b1;
      wr_d    = wr_i;
      ilv_d   = ilv_i;
      cnt_d   = '0;
      start_d = col_i;
      lm1_d   = (wr_i && wsingle_i) ? '0 : CNT_W'(len_full - 1'b1);
    end else if (act_q) begin
      if (cnt_q == lm1_q) act_d = 1'b0;
      else                cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      ilv_q   <= 1'b0;
      cnt_q   <= '0;
      lm1_q   <= '0;
      start_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      if (start_i) begin
        wr_q    <= wr_d;
        ilv_q   <= ilv_d;
        lm1_q   <= lm1_d;
        start_q <= start_d;
      end
    end
  end

  always_comb begin
    low_start = start_q[CNT_W-1:0];
    seq_low   = low_start + cnt_q;
    ilv_low   = low_start ^ cnt_q;
    pick_low  = ilv_q ? ilv_low : seq_low;
  end

  assign beat_o = act_q;
  assign wr_o   = act_q && wr_q;
  assign col_o  = {start_q[COL_W-1:CNT_W], (low_start & ~lm1_q) | (pick_low & lm1_q)};

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q <= lm1_q));
  // R9
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && wr_i && wsingle_i) |=> (act_q && lm1_q == '0 && col_o == $past(col_i)));
  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (act_q && cnt_q == '0));

  if (HI_W < 0) begin : g_bad_width
    initial $error("COL_W must cover the burst offset bits");
  end
endmodule

// File: rtl/sdr_rd_strobe.sv
module sdr_rd_strobe #(
  parameter int MAX_CL = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_beat_i,
  input  logic [1:0] cl_i,
  output logic       oe_o,
  output logic       vld_o
);
  logic [MAX_CL-1:0] sh_q, sh_d;
  int unsigned       tap_v, tap_e;

  always_comb begin
    sh_d = {sh_q[MAX_CL-2:0], rd_beat_i};
    tap_v = 32'(cl_i) - 1;
    tap_e = 32'(cl_i) - 2;
    vld_o = sh_q[tap_v];
    oe_o  = sh_q[tap_v] | sh_q[tap_e];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // R8
  vld_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> oe_o);
  // R8
  oe_leads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> !vld_o);
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 10,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              beat_o,
  output logic              beat_wr_o,
  output logic [COL_W-1:0]  col_o,
  output logic              rd_oe_o,
  output logic              rd_vld_o,
  output logic              mode_err_o,
  output logic [1:0]        cfg_blen_o,
  output logic              cfg_ilv_o,
  output logic [1:0]        cfg_cl_o,
  output logic              cfg_wsingle_o
);
  sdr_cmd_e  cmd;
  sdr_mode_t mode;
  logic      ld, acc, acc_wr, rd_beat;

  assign cmd    = sdr_cmd_e'(cmd_i);
  assign ld     = (cmd == CMD_LMODE);
  assign acc    = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  assign acc_wr = (cmd == CMD_WRITE);

  sdr_mode_reg #(.ADDR_W(ADDR_W)) mode_i (
    .clk(clk), .rst_n(rst_n), .ld_i(ld), .word_i(addr_i),
    .mode_o(mode), .err_o(mode_err_o)
  );

  sdr_beat_gen #(.COL_W(COL_W)) beat_i (
    .clk(clk), .rst_n(rst_n), .start_i(acc), .wr_i(acc_wr),
    .col_i(addr_i[COL_W-1:0]), .blen_log_i(mode.blen_log),
    .ilv_i(mode.ilv), .wsingle_i(mode.wsingle),
    .beat_o(beat_o), .wr_o(beat_wr_o), .col_o(col_o)
  );

  assign rd_beat = beat_o && !beat_wr_o;

  sdr_rd_strobe #(.MAX_CL(MAX_CL)) strobe_i (
    .clk(clk), .rst_n(rst_n), .rd_beat_i(rd_beat), .cl_i(mode.cl),
    .oe_o(rd_oe_o), .vld_o(rd_vld_o)
  );

  assign cfg_blen_o    = mode.blen_log;
  assign cfg_ilv_o     = mode.ilv;
  assign cfg_cl_o      = mode.cl;
  assign cfg_wsingle_o = mode.wsingle;

  // R11
  no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_o && !$past(beat_o) && !$past(beat_o, 2) && !$past(beat_o, 3)) |-> !rd_oe_o);
endmodule

// File: tb/sdram_burst_seq_tb_top.sv
module sdram_burst_seq_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cmd_i;
  logic [11:0] addr_i;
  logic        beat_o, beat_wr_o, rd_oe_o, rd_vld_o, mode_err_o;
  logic [9:0]  col_o;
  logic [1:0]  cfg_blen_o, cfg_cl_o;
  logic        cfg_ilv_o, cfg_wsingle_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  sdram_burst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .addr_i(addr_i),
    .beat_o(beat_o), .beat_wr_o(beat_wr_o), .col_o(col_o),
    .rd_oe_o(rd_oe_o), .rd_vld_o(rd_vld_o), .mode_err_o(mode_err_o),
    .cfg_blen_o(cfg_blen_o), .cfg_ilv_o(cfg_ilv_o),
    .cfg_cl_o(cfg_cl_o), .cfg_wsingle_o(cfg_wsingle_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_mode(input int bl, input int ilv, input int cl, input int op, input int ws);
    @(negedge clk);
    cmd_i  = 2'd1;
    addr_i = 12'((bl & 7) | (ilv << 3) | ((cl & 7) << 4) | ((op & 3) << 7) | (ws << 9));
    @(negedge clk);
    cmd_i  = 2'd0;
  endtask

  function automatic int exp_col(input int start, input int len, input int ilv, input int i);
    int base, off;
    base = start - (start % len);
    off  = start % len;
    if (ilv != 0) return base + (off ^ i);
    return base + ((off + i) % len);
  endfunction

  task automatic run_access(input int wr, input int start, input int bl, input int ilv,
                            input int cl, input int ws);
    int len;
    len = 1 << bl;
    if (wr != 0 && ws != 0) len = 1;
    @(negedge clk);
    cmd_i  = wr ? 2'd3 : 2'd2;
    addr_i = 12'(start);
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      cmd_i = 2'd0;
      chk("R4 beat", int'(beat_o), int'(i < len));
      if (i < len) begin
        chk("R4 beat_wr", int'(beat_wr_o), wr);
        chk(ilv ? "R6 column" : "R5 column", int'(col_o), exp_col(start, len, ilv, i));
      end
      if (wr != 0) begin
        chk("R11 oe", int'(rd_oe_o), 0);
        chk("R11 vld", int'(rd_vld_o), 0);
      end else begin
        chk("R7 vld", int'(rd_vld_o), int'(i >= cl && i < cl + len));
        chk("R8 oe", int'(rd_oe_o), int'(i >= cl - 1 && i < cl + len));
      end
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    cmd_i  = 2'd0;
    addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 blen", int'(cfg_blen_o), 0);
    chk("R1 ilv", int'(cfg_ilv_o), 0);
    chk("R1 cl", int'(cfg_cl_o), 3);
    chk("R1 wsingle", int'(cfg_wsingle_o), 0);
    chk("R1 err", int'(mode_err_o), 0);
    chk("R1 oe", int'(rd_oe_o), 0);
    chk("R1 vld", int'(rd_vld_o), 0);
    chk("R1 beat", int'(beat_o), 0);

    run_access(0, 5, 0, 0, 3, 0);

    for (int bl = 0; bl < 4; bl++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int cl = 2; cl < 4; cl++)
          for (int ws = 0; ws < 2; ws++) begin
            load_mode(bl, ilv, cl, 0, ws);
            chk("R2 blen", int'(cfg_blen_o), bl);
            chk("R2 ilv", int'(cfg_ilv_o), ilv);
            chk("R2 cl", int'(cfg_cl_o), cl);
            chk("R9 wsingle", int'(cfg_wsingle_o), ws);
            chk("R2 err", int'(mode_err_o), 0);
            for (int s = 0; s < 10; s++) begin
              run_access(0, (s * 173) % 1024, bl, ilv, cl, ws);
              run_access(1, (s * 173) % 1024, bl, ilv, cl, ws);
            end
          end

    load_mode(3, 0, 2, 0, 0);
    load_mode(4, 1, 3, 0, 1);
    chk("R3 err bl", int'(mode_err_o), 1);
    chk("R3 blen held", int'(cfg_blen_o), 3);
    chk("R3 ilv held", int'(cfg_ilv_o), 0);
    load_mode(1, 1, 1, 0, 1);
    chk("R3 err cl", int'(mode_err_o), 1);
    chk("R3 cl held", int'(cfg_cl_o), 2);
    load_mode(1, 1, 3, 2, 1);
    chk("R3 err op", int'(mode_err_o), 1);
    chk("R3 wsingle held", int'(cfg_wsingle_o), 0);
    @(negedge clk);
    chk("R3 err sticky", int'(mode_err_o), 1);
    load_mode(3, 0, 2, 0, 0);
    chk("R2 err cleared", int'(mode_err_o), 0);

    @(negedge clk);
    cmd_i  = 2'd2;
    addr_i = 12'd0;
    @(negedge clk);
    cmd_i = 2'd0;
    chk("R10 read beat0", int'(col_o), 0);
    @(negedge clk);
    chk("R10 read beat1", int'(col_o), 1);
    chk("R8 oe early", int'(rd_oe_o), 1);
    cmd_i  = 2'd3;
    addr_i = 12'd20;
    @(negedge clk);
    cmd_i  = 2'd1;
    addr_i = 12'h020;
    chk("R10 write beat0 wr", int'(beat_wr_o), 1);
    chk("R10 write beat0 col", int'(col_o), 20);
    chk("R7 drain vld0", int'(rd_vld_o), 1);
    @(negedge clk);
    cmd_i = 2'd0;
    chk("R10 write beat1 col", int'(col_o), 21);
    chk("R7 drain vld1", int'(rd_vld_o), 1);
    @(negedge clk);
    chk("R10 mode load kept burst", int'(col_o), 22);
    chk("R11 strobe after drain vld", int'(rd_vld_o), 0);
    chk("R11 strobe after drain oe", int'(rd_oe_o), 0);
    repeat (8) @(negedge clk);
    chk("R4 idle", int'(beat_o), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule